// File: doc/BRIEF.md
# Dual Four-Bit Addressable Storage Register

This block holds two small banks of storage bits that share one binary address, one active-low enable and one active-low clear. Each bank has its own serial data input and its own parallel outputs. Enable and clear together pick one of four modes. In addressable-latch mode, one bit per bank is written from that bank's data input. In memory mode, everything holds. In demultiplexer mode, the addressed bit takes the data and every other bit of the bank is forced low. In clear mode, all bits go low. A typical use is serial-to-parallel loading: the address steps through each position while the data input carries one bit per step, and the parallel word is then read at the outputs.

This is a synchronous version of the behaviour. All inputs are sampled on the rising clock edge, and the outputs come straight from state registers. Because nothing is transparent, an address that changes between edges cannot cause a write to a wrong bit. A synchronous active-high reset clears every bit and acts separately from the functional clear input.

Top module: `dual_addr_latch`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `q` reads 0 after that edge, whatever the other inputs are.
- R2: With `clr_n`=0 and `en_n`=1 (clear mode), every bit of `q` reads 0 after the edge.
- R3: With `clr_n`=1 and `en_n`=1 (memory mode), `q` keeps its value across the edge for any `addr` and `din`.
- R4: With `clr_n`=1 and `en_n`=0 (addressable-latch mode), the addressed bit of bank b takes `din[b]` at the edge.
- R5: In addressable-latch mode, the three unaddressed bits of each bank keep their values.
- R6: With `clr_n`=0 and `en_n`=0 (demultiplexer mode), the addressed bit of bank b takes `din[b]` at the edge.
- R7: In demultiplexer mode, the unaddressed bits of each bank read 0 after the edge.
- R8: `addr` is a binary index with bit 0 as the least significant bit, so value k selects bit k of a bank. Bank 0 occupies `q[3:0]` and bank 1 occupies `q[7:4]`, and bit k of bank b is `q[4*b+k]`.
- R9: `q` changes only at a rising clock edge. An input change between edges does not appear on `q` before the next edge.
- R10: The two banks share `addr`, `en_n` and `clr_n`, but each bank is written only from its own `din` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all bits |
| en_n | input | 1 | Active-low enable; together with clr_n it selects the mode |
| clr_n | input | 1 | Active-low functional clear; together with en_n it selects the mode |
| addr | input | 2 | Bit index within each bank, with bit 0 as the least significant bit |
| din | input | 2 | Data input, one bit per bank (bit b feeds bank b) |
| q | output | 8 | Stored bits; bank b occupies q[4*b+3:4*b] |

## Verification
The bench targets the corners where one mode could be confused with another. If demultiplexer mode were built as a plain addressed write, the stale neighbours would survive, and the sweeps would expose them. A latch mode that zeroes its neighbours would wipe out previously loaded bits during a serial walk. Every combination of mode, address and data is applied from several preloaded states, so the following faults each show up as wrong bits against the arithmetic model:
- swapped address bits, which scramble the serial-to-parallel word;
- a bank written from the other bank's data input;
- a memory mode that leaks the inputs through.

A mid-cycle input change is also checked, to catch any output path that is not registered.

// File: rtl/dual_addr_latch.sv
module dual_addr_latch #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_BITS = 4,
  parameter int ADDR_W    = $clog2(BANK_BITS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           en_n,
  input  logic                           clr_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_BANKS-1:0]           din,
  output logic [NUM_BANKS*BANK_BITS-1:0] q
);

  localparam int TOTAL = NUM_BANKS * BANK_BITS;

  logic             write_on;
  logic             wipe_others;
  logic [TOTAL-1:0] state_q;

  // write: en_n low; neighbours forced low: clr_n low
  assign write_on    = !en_n;
  assign wipe_others = !clr_n;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar i = 0; i < BANK_BITS; i++) begin : g_bit
      logic hit;
      logic nxt;
      assign hit = (addr == ADDR_W'(i));

      always_comb begin
        if (write_on && hit)  nxt = din[b];
        else if (wipe_others) nxt = 1'b0;
        else                  nxt = state_q[b*BANK_BITS+i];
      end

      always_ff @(posedge clk) begin
        if (rst) state_q[b*BANK_BITS+i] <= 1'b0;
        else     state_q[b*BANK_BITS+i] <= nxt;
      end
    end
  end

  assign q = state_q;

endmodule

// File: rtl/dual_addr_latch_chk.sv
module dual_addr_latch_chk #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_BITS = 4,
  parameter int ADDR_W    = $clog2(BANK_BITS)
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           en_n,
  input logic                           clr_n,
  input logic [ADDR_W-1:0]              addr,
  input logic [NUM_BANKS-1:0]           din,
  input logic [NUM_BANKS*BANK_BITS-1:0] q
);

  localparam int TOTAL = NUM_BANKS * BANK_BITS;

  logic [TOTAL-1:0] sel_mask;

  always_comb begin
    sel_mask = '0;
    for (int b = 0; b < NUM_BANKS; b++) sel_mask[b*BANK_BITS + int'(addr)] = 1'b1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (q == '0));

  // R2
  clear_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && en_n) |=> (q == '0));

  // R3
  memory_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && en_n) |=> $stable(q));

  // R5
  latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !en_n) |=> ((q & ~$past(sel_mask)) == ($past(q) & ~$past(sel_mask))));

  // R7
  demux_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !en_n) |=> ((q & ~$past(sel_mask)) == '0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // R4 R8 R10
    latch_write_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_n && !en_n) |=> (q[b*BANK_BITS + int'($past(addr))] == $past(din[b])));
    // R6
    demux_write_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr_n && !en_n) |=> (q[b*BANK_BITS + int'($past(addr))] == $past(din[b])));
  end

endmodule

bind dual_addr_latch dual_addr_latch_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_BITS(BANK_BITS),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk),
  .rst(rst),
  .en_n(en_n),
  .clr_n(clr_n),
  .addr(addr),
  .din(din),
  .q(q)
);

// File: tb/test_dual_addr_latch.sv
module test_dual_addr_latch;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_n = 1'b1;
  logic       clr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [1:0] din = '0;
  logic [7:0] q;

  logic [7:0] model = '0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_addr_latch i_dual_addr_latch (
    .clk(clk), .rst(rst), .en_n(en_n), .clr_n(clr_n),
    .addr(addr), .din(din), .q(q)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected=%b", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] next_model(logic [7:0] cur, logic e_n, logic c_n,
                                            logic [1:0] a, logic [1:0] d);
    logic [7:0] r = cur;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 4; i++) begin
        bit sel = (int'(a) == i);
        case ({c_n, e_n})
          2'b10: if (sel) r[4*b+i] = d[b];
          2'b00: r[4*b+i] = sel ? d[b] : 1'b0;
          2'b01: r[4*b+i] = 1'b0;
          default: ;
        endcase
      end
    return r;
  endfunction

  function automatic string mode_tag(logic e_n, logic c_n);
    case ({c_n, e_n})
      2'b10:   return "R4 R5 R8 R10 latch";
      2'b11:   return "R3 memory";
      2'b00:   return "R6 R7 R8 R10 demux";
      default: return "R2 clear";
    endcase
  endfunction

  task automatic step(logic e_n, logic c_n, logic [1:0] a, logic [1:0] d, string tag);
    @(negedge clk);
    en_n = e_n; clr_n = c_n; addr = a; din = d;
    @(posedge clk);
    #1;
    model = next_model(model, e_n, c_n, a, d);
    check(tag, q, model);
  endtask

  task automatic walk(logic [3:0] pa, logic [3:0] pb, string tag);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 2'(k), {pb[k], pa[k]}, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: q=%b expected=finish", q);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset", q, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    // serial-to-parallel walk, distinct pattern per bank
    walk(4'b1011, 4'b0110, "R4 R8 R10 walk");
    check("R8 R10 word", q, 8'b0110_1011);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 2'(k), 2'(3 - k), "R3 hold");

    // R9: mid-cycle input change is not visible before the edge
    @(negedge clk);
    en_n = 1'b0; clr_n = 1'b0; addr = 2'd2; din = 2'b11;
    #2;
    check("R9 between edges", q, model);
    @(posedge clk);
    #1;
    model = next_model(model, 1'b0, 1'b0, 2'd2, 2'b11);
    check("R9 at edge", q, model);

    // exhaustive sweep from several preloaded states
    for (int r = 0; r < 4; r++) begin
      logic [3:0] pa = 4'(r * 5 + 3);
      logic [3:0] pb = ~4'(r * 3 + 1);
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 4; a++)
          for (int d = 0; d < 4; d++) begin
            walk(pa, pb, "R4 preload");
            step(m[0], m[1], 2'(a), 2'(d), mode_tag(m[0], m[1]));
          end
    end

    // reset over a loaded state while clear is inactive
    walk(4'hF, 4'hF, "R4 refill");
    @(negedge clk);
    rst = 1'b1; en_n = 1'b0; clr_n = 1'b1; din = 2'b11;
    @(posedge clk);
    #1;
    model = '0;
    check("R1 reset wins", q, model);
    @(negedge clk);
    rst = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule